// File: doc/BRIEF.md
# QoS Priority Arbiter with Least-Recently-Granted Tie-Break

This block decides which of N requesters gets a shared interconnect port in the current cycle. The decision is made in two stages. First, each pending request is ranked by a 4-bit priority value, and a larger value ranks higher. Second, if several pending requests share the top value, the one granted least recently wins.

Each port takes its priority from one of two places. It can use the QoS value that arrives with the request. It can also use a value held in a per-port register, chosen by a per-port enable bit.

The grant is combinational and is either one-hot or all zeros. A consumer takes the offered grant by raising `accept` in the same cycle. Only an accepted grant changes the recency order: the winner moves to the most-recent end, and every other port keeps its relative place.

After reset all priorities are equal by default. Arbitration then reduces to plain least-recently-granted, starting from port 0. The block adds no aging of its own, so a port with a low QoS value can wait for as long as higher-QoS requests keep arriving.

Internally, each cycle falls into one of three phases, which are classifications rather than registered states:
- **IDLE**: no request is pending.
- **OFFER**: a grant is shown but not accepted.
- **TAKE**: a grant is shown and accepted.

The only transition that changes state is TAKE, which updates the recency order. IDLE and OFFER hold it.

Top module: `qos_lrg_arbiter`

## Requirements
- R1: `grant` is one-hot or zero, and never has a bit set for a port whose `req` bit is low.
- R2: With no request pending, `grant` is all zeros, and the recency order is unchanged in the next cycle.
- R3: A port's effective priority is its `ovr_qos` field when its `ovr_en` bit is 1, and its `qos_in` field otherwise. The field for port i sits at bits [4i+3:4i].
- R4: The granted port has the largest effective priority of all pending requests, whatever the recency order.
- R5: Among pending requests that share the largest effective priority, the port granted least recently wins.
- R6: After reset the recency order runs from port 0 (least recent) to port N-1 (most recent), so the first tie goes to the lowest index.
- R7: When `accept` is 1 and `grant` is non-zero, the granted port becomes the most recent, and the other ports keep their relative order.
- R8: When `accept` is 0, the recency order does not change, so identical inputs in the next cycle give the same grant.
- R9: `grant_idx` is the binary index of the set `grant` bit, and 0 when `grant` is zero.
- R10: No aging is added. A pending port whose priority is lower than that of another pending port is never granted, however long it waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N | Request bit for each port |
| qos_in | input | N*QW | QoS value arriving with each request, 4 bits per port |
| ovr_en | input | N | Per-port select for the register priority |
| ovr_qos | input | N*QW | Register priority value for each port |
| accept | input | 1 | Consumer takes the offered grant this cycle |
| grant | output | N | One-hot grant, or zero |
| grant_idx | output | IW | Index of the granted port |

## Verification
The bench drives equal-priority requests straight out of reset. A design with the wrong initial order, or one that shifts the order wrongly on accept, would grant in a different rotation from the reference queue.

It holds `accept` low while the requests stay the same. A design that updates recency on every offer, rather than on every accept, would move the grant on to another port.

It mixes override and bus priorities. A design with an inverted select, or a misplaced 4-bit field, would pick the wrong winner.

It keeps a high-priority port requesting beside a low-priority one for many accepted cycles. A design with hidden aging, or one that lets recency beat priority, would eventually grant the low port.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_TAKE  = 2'd2
    } arb_phase_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/qarb_qos_sel.sv
module qarb_qos_sel #(
    parameter int N  = 4,
    parameter int QW = 4
) (
    input  logic [N*QW-1:0] qos_in,
    input  logic [N-1:0]    ovr_en,
    input  logic [N*QW-1:0] ovr_qos,
    output logic [N*QW-1:0] eff_qos
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign eff_qos[g*QW +: QW] = ovr_en[g] ? ovr_qos[g*QW +: QW]
                                               : qos_in[g*QW +: QW];
    end
endmodule

// File: rtl/qarb_top_filter.sv
module qarb_top_filter #(
    parameter int N  = 4,
    parameter int QW = 4
) (
    input  logic [N-1:0]    req,
    input  logic [N*QW-1:0] eff_qos,
    output logic [N-1:0]    top_mask
);
    logic [QW-1:0] best;

    always_comb begin
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (eff_qos[i*QW +: QW] > best)) begin
                best = eff_qos[i*QW +: QW];
            end
        end
        for (int i = 0; i < N; i++) begin
            top_mask[i] = req[i] && (eff_qos[i*QW +: QW] == best);
        end
    end
endmodule

// File: rtl/qarb_lrg_order.sv
module qarb_lrg_order #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    cand,
    input  logic            upd,
    output logic [N-1:0]    win_oh,
    output logic [IW-1:0]   win_idx,
    output logic            win_any,
    output logic [N*IW-1:0] ord_flat
);
    logic [IW-1:0] ord_q [N];
    logic [IW-1:0] ord_d [N];
    logic [IW-1:0] wpos;

    // Scan from least to most recently granted; first candidate wins.
    always_comb begin
        win_any = 1'b0;
        wpos    = '0;
        win_idx = '0;
        for (int p = 0; p < N; p++) begin
            if (!win_any && cand[ord_q[p]]) begin
                win_any = 1'b1;
                wpos    = IW'(p);
                win_idx = ord_q[p];
            end
        end
        for (int i = 0; i < N; i++) begin
            win_oh[i] = win_any && (win_idx == IW'(i));
        end
    end

    // Close the gap left by the winner and append it at the recent end.
    always_comb begin
        for (int p = 0; p < N - 1; p++) begin
            ord_d[p] = (p >= int'(wpos)) ? ord_q[p+1] : ord_q[p];
        end
        ord_d[N-1] = win_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin
                ord_q[p] <= IW'(p);
            end
        end else if (upd && win_any) begin
            for (int p = 0; p < N; p++) begin
                ord_q[p] <= ord_d[p];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign ord_flat[g*IW +: IW] = ord_q[g];
    end
endmodule

// File: rtl/qos_lrg_arbiter.sv
module qos_lrg_arbiter
    import qarb_pkg::*;
#(
    parameter int N  = 4,
    parameter int QW = 4,
    parameter int IW = idx_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*QW-1:0] qos_in,
    input  logic [N-1:0]    ovr_en,
    input  logic [N*QW-1:0] ovr_qos,
    input  logic            accept,
    output logic [N-1:0]    grant,
    output logic [IW-1:0]   grant_idx
);
    logic [N*QW-1:0] eff_qos;
    logic [N-1:0]    top_mask;
    logic            win_any;
    logic            upd;
    logic [N*IW-1:0] ord_flat;
    arb_phase_e      phase;

    qarb_qos_sel #(.N(N), .QW(QW)) u_sel (
        .qos_in  (qos_in),
        .ovr_en  (ovr_en),
        .ovr_qos (ovr_qos),
        .eff_qos (eff_qos)
    );

    qarb_top_filter #(.N(N), .QW(QW)) u_filt (
        .req      (req),
        .eff_qos  (eff_qos),
        .top_mask (top_mask)
    );

    qarb_lrg_order #(.N(N), .IW(IW)) u_ord (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (top_mask),
        .upd      (upd),
        .win_oh   (grant),
        .win_idx  (grant_idx),
        .win_any  (win_any),
        .ord_flat (ord_flat)
    );

    always_comb begin
        unique case ({win_any, accept})
            2'b10:   phase = ARB_OFFER;
            2'b11:   phase = ARB_TAKE;
            default: phase = ARB_IDLE;
        endcase
    end

    assign upd = (phase == ARB_TAKE);
endmodule

// File: rtl/qarb_checker.sv
module qarb_checker #(
    parameter int N  = 4,
    parameter int QW = 4,
    parameter int IW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    req,
    input logic            accept,
    input logic [N-1:0]    grant,
    input logic [IW-1:0]   grant_idx,
    input logic [N*IW-1:0] ord_flat
);
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r1_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (grant == '0));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> $stable(ord_flat));
    a_r8_no_accept_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(ord_flat));
    a_r7_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && grant != '0) |=> (ord_flat[N*IW-1 -: IW] == $past(grant_idx)));
    a_r9_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> grant[grant_idx]);
endmodule

bind qos_lrg_arbiter qarb_checker #(.N(N), .QW(QW), .IW(IW)) u_chk (.*);

// File: tb/qos_lrg_arbiter_test.sv
`timescale 1ns/1ps
module qos_lrg_arbiter_test;
    localparam int N = 4;
    localparam int QW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [15:0]   qos_in = '0;
    logic [N-1:0]  ovr_en = '0;
    logic [15:0]   ovr_qos = '0;
    logic          accept = 1'b0;
    logic [N-1:0]  grant;
    logic [1:0]    grant_idx;

    int checks = 0;
    int errors = 0;
    int order[$];

    always #10 clk = ~clk;

    qos_lrg_arbiter #(.N(N), .QW(QW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .qos_in(qos_in),
        .ovr_en(ovr_en), .ovr_qos(ovr_qos), .accept(accept),
        .grant(grant), .grant_idx(grant_idx)
    );

    task automatic step(input logic [3:0] r, input logic [15:0] q,
                        input logic [3:0] oe, input logic [15:0] oq,
                        input logic acc, input string tag);
        int best;
        int win;
        int e;
        logic [3:0] exp_g;
        @(negedge clk);
        req = r; qos_in = q; ovr_en = oe; ovr_qos = oq; accept = acc;
        #2;
        best = 0;
        for (int i = 0; i < N; i++) begin
            e = oe[i] ? int'(oq[i*4 +: 4]) : int'(q[i*4 +: 4]);
            if (r[i] && e > best) best = e;
        end
        win = -1;
        foreach (order[k]) begin
            e = oe[order[k]] ? int'(oq[order[k]*4 +: 4]) : int'(q[order[k]*4 +: 4]);
            if (win < 0 && r[order[k]] && e == best) win = order[k];
        end
        exp_g = (win < 0) ? 4'b0 : 4'(1 << win);
        checks++;
        if (grant !== exp_g) begin
            errors++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp_g);
        end
        checks++;
        if (grant_idx !== ((win < 0) ? 2'd0 : 2'(win))) begin
            errors++;
            $display("FAIL R9 grant_idx actual=%0d expected=%0d", grant_idx,
                     (win < 0) ? 0 : win);
        end
        if (acc && win >= 0) begin
            foreach (order[k]) begin
                if (order[k] == win) begin
                    order.delete(k);
                    break;
                end
            end
            order.push_back(win);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) order.push_back(i);
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        checks++;
        if (grant !== 4'b0) begin
            errors++;
            $display("FAIL R2 reset grant actual=%b expected=0000", grant);
        end
        step(4'b0000, 16'h0, 4'h0, 16'h0, 1'b1, "R2 idle");
        // R6: equal priorities, first tie goes to port 0
        step(4'b1111, 16'h0, 4'h0, 16'h0, 1'b0, "R6 reset order");
        // R8: no accept, grant must not move
        step(4'b1111, 16'h0, 4'h0, 16'h0, 1'b0, "R8 hold");
        // R5 R7: accepted rotation 0,1,2,3,0
        for (int k = 0; k < 5; k++) step(4'b1111, 16'h0, 4'h0, 16'h0, 1'b1, "R5 R7 rotate");
        step(4'b1010, 16'h0, 4'h0, 16'h0, 1'b1, "R5 subset tie");
        step(4'b1011, 16'h0, 4'h0, 16'h0, 1'b1, "R7 relative order");
        // R4: port 3 has higher QoS even when most recent
        step(4'b1111, 16'h9222, 4'h0, 16'h0, 1'b1, "R4 priority");
        step(4'b1111, 16'h9222, 4'h0, 16'h0, 1'b1, "R4 priority repeat");
        // R3: override raises port 1, disabled override on port 2 ignored
        step(4'b1111, 16'h3303, 4'b0010, 16'h0FC0, 1'b1, "R3 override on");
        step(4'b1111, 16'h3033, 4'b0000, 16'h0F00, 1'b1, "R3 override off");
        // R10: low-priority port 1 never granted
        for (int k = 0; k < 10; k++) step(4'b0011, 16'h001F, 4'h0, 16'h0, 1'b1, "R10 no aging");
        step(4'b0000, 16'h0, 4'h0, 16'h0, 1'b1, "R2 idle later");
        step(4'b1111, 16'h0, 4'h0, 16'h0, 1'b0, "R2 order held");
        // R1: broad mixed traffic against the reference queue
        for (int k = 0; k < 400; k++) begin
            step(4'($urandom), 16'($urandom & 32'h3333), 4'($urandom),
                 16'($urandom), 1'($urandom), "R1 mixed");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule